// File: doc/BRIEF.md
# Interleaved Time-Slot Shared Memory Arbiter

This block shares one single-port synchronous word memory among seventeen requesters on a schedule that never changes. Requester 0 is privileged and owns every even-numbered slot. The odd slots go to requesters 1 through 16 in ascending order, one each, and then the sequence starts again at requester 1. One full rotation takes 32 clocks. Each clock is one slot. A slot belongs to its owner whether or not the owner uses it, so an idle owner leaves the memory unused for that clock.

Each requester has a valid/ready request channel that carries a write flag, a word address and write data. `req_ready[i]` is high during exactly the slots that requester i owns, and it does not depend on `req_valid`. A request is taken on a clock where valid and ready are both high. A requester that raises valid outside its slot must keep valid, the write flag, the address and the data unchanged until it is accepted. There is no other back-pressure. A read response cannot be refused.

On acceptance the block pulses `grant[i]` for that one clock. A write commits at the end of the slot. A read returns its word on the shared `rsp_data` bus one clock later, together with a one-hot `rsp_valid` that names the requester. The memory holds 2^ADDR_W words of 32 bits. ADDR_W = 16 gives the full 256 KB. The default of 10 keeps elaboration small.

Top module: `tsa_mem_arbiter`

## Requirements
- R1: While the synchronous reset `rst` is held, and in the first clock after it is released, `req_ready` equals 17'h00001 (slot 0, owned by requester 0). In that same clock `grant` and `rsp_valid` are all zero.
- R2: Counting clocks from the release of reset as c = 0, 1, 2, …, requester 0 owns every clock where c is even. Owning means its `req_ready` bit is the only bit set.
- R3: In an odd clock c, the only `req_ready` bit set is bit ((c mod 32) − 1)/2 + 1. The odd slots therefore visit requesters 1 to 16 in ascending order, and the schedule repeats every 32 clocks.
- R4: The schedule is strict. A requester with a pending request is never granted outside its own slots, even when the owner of the current slot is idle.
- R5: `grant[i]` is high exactly on clocks where `req_valid[i]` and `req_ready[i]` are both high. `req_ready` does not depend on `req_valid`.
- R6: A write accepted in a slot (`req_wr[i]` = 1) stores its 32-bit word at its address. A read accepted in any later slot returns that word.
- R7: A read accepted in clock c raises `rsp_valid[i]` for requester i only, in clock c+1, with the stored word on `rsp_data`. A write raises no `rsp_valid`.
- R8: When all seventeen requesters keep requests pending, any 32 consecutive clocks give requester 0 exactly 16 grants and every other requester exactly one.
- R9: Every address from 0 to 2^ADDR_W − 1 holds its own 32-bit word. The lowest and highest addresses do not alias.
- R10: At most one `grant` bit and at most one `rsp_valid` bit are high in any clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 17 | Request pending, one bit per requester |
| req_wr | input | 17 | 1 = write, 0 = read, one bit per requester |
| req_addr | input | 17*ADDR_W | Word address; requester i uses bits [i*ADDR_W +: ADDR_W] |
| req_wdata | input | 17*32 | Write data; requester i uses bits [i*32 +: 32] |
| req_ready | output | 17 | One-hot slot owner for the current clock |
| grant | output | 17 | One-clock acceptance pulse |
| rsp_valid | output | 17 | Read data valid, one clock after a read is accepted |
| rsp_data | output | 32 | Shared read data bus |

## Verification
`req_ready` and `grant` are combinational in the current slot, so they are checked in the same clock the request is driven. `rsp_valid` and `rsp_data` pass through one register and are checked one clock after the grant. A written word must be readable in any later slot of any requester. The bench drives inputs on the falling edge and samples 1 ns later. It keeps its own count of clocks since reset and derives the expected slot owner from that count alone. Each expectation is compared in the clock where the timing above places the result.

// File: rtl/tsa_pkg.sv
package tsa_pkg;
  localparam int WORD_W = 32;

  // Owner of a slot index: even slots -> requester 0, odd slots step 1..N.
  function automatic int unsigned slot_owner(int unsigned slot);
    if ((slot % 2) == 0) return 0;
    return (slot / 2) + 1;
  endfunction
endpackage

// File: rtl/tsa_slot_seq.sv
module tsa_slot_seq #(
  parameter int N_SEC = 16
) (
  input  logic           clk,
  input  logic           rst,
  output logic [N_SEC:0] owner_oh
);
  localparam int NREQ   = N_SEC + 1;
  localparam int SLOTS  = 2 * N_SEC;
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int LAST   = SLOTS - 1;

  logic [SLOT_W-1:0] slot_q;

  always_ff @(posedge clk) begin
    if (rst) slot_q <= '0;
    else if (slot_q == SLOT_W'(LAST)) slot_q <= '0;
    else slot_q <= slot_q + 1'b1;
  end

  for (genvar g = 0; g < NREQ; g++) begin : g_dec
    assign owner_oh[g] = (tsa_pkg::slot_owner(32'(slot_q)) == 32'(g));
  end

  AST_OWNER_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot(owner_oh)); // R3

  AST_CORE0_LEAVES: assert property (@(posedge clk) disable iff (rst)
    owner_oh[0] |=> !owner_oh[0]); // R2

  AST_CORE0_RETURNS: assert property (@(posedge clk) disable iff (rst)
    !owner_oh[0] |=> owner_oh[0]); // R2

  for (genvar k = 1; k <= N_SEC; k++) begin : g_step
    localparam int NXT = (k == N_SEC) ? 1 : k + 1;
    AST_ODD_STEP: assert property (@(posedge clk) disable iff (rst)
      owner_oh[k] |=> ##1 owner_oh[NXT]); // R3
  end
endmodule

// File: rtl/tsa_req_mux.sv
module tsa_req_mux #(
  parameter int NREQ   = 17,
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NREQ-1:0]        owner_oh,
  input  logic [NREQ-1:0]        req_valid,
  input  logic [NREQ-1:0]        req_wr,
  input  logic [NREQ*ADDR_W-1:0] req_addr,
  input  logic [NREQ*DATA_W-1:0] req_wdata,
  output logic [NREQ-1:0]        grant,
  output logic                   mem_en,
  output logic                   mem_we,
  output logic [ADDR_W-1:0]      mem_addr,
  output logic [DATA_W-1:0]      mem_wdata
);
  assign grant  = owner_oh & req_valid;
  assign mem_en = |grant;
  assign mem_we = |(grant & req_wr);

  always_comb begin
    mem_addr  = '0;
    mem_wdata = '0;
    for (int i = 0; i < NREQ; i++) begin
      mem_addr  = mem_addr  | (req_addr[i*ADDR_W +: ADDR_W]  & {ADDR_W{grant[i]}});
      mem_wdata = mem_wdata | (req_wdata[i*DATA_W +: DATA_W] & {DATA_W{grant[i]}});
    end
  end

  AST_GRANT_IN_SLOT: assert property (@(posedge clk) disable iff (rst)
    (grant & ~owner_oh) == '0); // R4

  AST_GRANT_SINGLE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant)); // R10
endmodule

// File: rtl/tsa_sp_ram.sv
module tsa_sp_ram #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en && we) mem[addr] <= wdata;
    if (en && !we) rdata <= mem[addr];
  end

  AST_WE_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    we |-> en); // R6
endmodule

// File: rtl/tsa_mem_arbiter.sv
module tsa_mem_arbiter #(
  parameter int N_SEC  = 16,
  parameter int ADDR_W = 10,
  parameter int NREQ   = N_SEC + 1,
  parameter int DATA_W = tsa_pkg::WORD_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NREQ-1:0]        req_valid,
  input  logic [NREQ-1:0]        req_wr,
  input  logic [NREQ*ADDR_W-1:0] req_addr,
  input  logic [NREQ*DATA_W-1:0] req_wdata,
  output logic [NREQ-1:0]        req_ready,
  output logic [NREQ-1:0]        grant,
  output logic [NREQ-1:0]        rsp_valid,
  output logic [DATA_W-1:0]      rsp_data
);
  logic [NREQ-1:0]   owner_oh;
  logic              mem_en, mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_wdata;
  logic [NREQ-1:0]   rsp_q;

  tsa_slot_seq #(.N_SEC(N_SEC)) u_seq (
    .clk(clk), .rst(rst), .owner_oh(owner_oh)
  );

  tsa_req_mux #(.NREQ(NREQ), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mux (
    .clk(clk), .rst(rst), .owner_oh(owner_oh),
    .req_valid(req_valid), .req_wr(req_wr),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .grant(grant), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  tsa_sp_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
    .clk(clk), .rst(rst), .en(mem_en), .we(mem_we),
    .addr(mem_addr), .wdata(mem_wdata), .rdata(rsp_data)
  );

  always_ff @(posedge clk) begin
    if (rst) rsp_q <= '0;
    else rsp_q <= grant & ~req_wr;
  end

  assign req_ready = owner_oh;
  assign rsp_valid = rsp_q;

  AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(rsp_valid)); // R10

  for (genvar i = 0; i < NREQ; i++) begin : g_rsp
    AST_RSP_AFTER_SLOT: assert property (@(posedge clk) disable iff (rst)
      rsp_valid[i] |-> $past(req_ready[i] && req_valid[i] && !req_wr[i])); // R7
  end
endmodule

// File: tb/tb_tsa_mem_arbiter.sv
module tb_tsa_mem_arbiter;
  localparam int NREQ = 17;
  localparam int AW   = 10;
  localparam int DW   = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [NREQ-1:0]    req_valid, req_wr, req_ready, grant, rsp_valid;
  logic [NREQ*AW-1:0] req_addr;
  logic [NREQ*DW-1:0] req_wdata;
  logic [DW-1:0]      rsp_data;

  tsa_mem_arbiter #(.N_SEC(16), .ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_wr(req_wr),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .grant(grant), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  int bc;
  always @(posedge clk) begin
    if (rst) bc <= 0;
    else bc <= bc + 1;
  end

  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  function automatic int exp_owner(int c);
    if (c % 2 == 0) return 0;
    return ((c % 32) / 2) + 1;
  endfunction

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_access(int c, bit wr, int addr, logic [31:0] wd, output logic [31:0] rd);
    int w;
    w = 0;
    rd = '0;
    @(negedge clk);
    req_valid[c] = 1'b1;
    req_wr[c] = wr;
    req_addr[c*AW +: AW] = AW'(addr);
    req_wdata[c*DW +: DW] = wd;
    #1;
    while (!grant[c] && w < 40) begin
      @(negedge clk); #1; w++;
    end
    // R5: accepted only where ready and valid meet, in own slot
    chk(grant[c] && req_ready[c] && exp_owner(bc) == c, "R5", "grant in own slot",
        64'(grant), 64'(1) << exp_owner(bc));
    @(negedge clk);
    req_valid[c] = 1'b0;
    #1;
    if (!wr) begin
      chk(rsp_valid == (17'(1) << c), "R7", "rsp_valid one clock after read",
          64'(rsp_valid), 64'(1) << c);
      rd = rsp_data;
    end else begin
      chk(rsp_valid == '0, "R7", "no response for write", 64'(rsp_valid), 64'(0));
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk(req_ready == 17'h1, "R1", "ready during reset", 64'(req_ready), 64'h1);
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk(req_ready == 17'h1 && grant == '0 && rsp_valid == '0, "R1", "first slot after reset",
        64'(req_ready), 64'h1);
  endtask

  task automatic t_schedule();
    int bad2, bad3;
    bad2 = 0; bad3 = 0;
    for (int k = 0; k < 64; k++) begin
      @(negedge clk); #1;
      if (req_ready != (17'(1) << exp_owner(bc))) begin
        if (bc % 2 == 0) bad2++; else bad3++;
        $display("FAIL R2/R3 slot %0d: actual %0h expected %0h", bc, req_ready,
                 17'(1) << exp_owner(bc));
      end
    end
    chk(bad2 == 0, "R2", "core 0 owns even slots", 64'(bad2), 64'(0));
    chk(bad3 == 0, "R3", "odd slots rotate 1..16", 64'(bad3), 64'(0));
  endtask

  task automatic t_fairness();
    int cnt [NREQ];
    int bad10, bad5;
    bad10 = 0; bad5 = 0;
    for (int i = 0; i < NREQ; i++) cnt[i] = 0;
    @(negedge clk);
    for (int i = 0; i < NREQ; i++) begin
      req_wr[i] = 1'b0;
      req_addr[i*AW +: AW] = AW'(i);
    end
    req_valid = '1;
    for (int k = 0; k < 32; k++) begin
      #1;
      for (int i = 0; i < NREQ; i++) if (grant[i]) cnt[i]++;
      if ($countones(grant) != 1 || $countones(rsp_valid) > 1) bad10++;
      if (grant != (req_ready & req_valid) || req_ready != (17'(1) << exp_owner(bc))) bad5++;
      @(negedge clk);
    end
    req_valid = '0;
    chk(bad10 == 0, "R10", "single grant and response", 64'(bad10), 64'(0));
    chk(bad5 == 0, "R5", "grant is ready and valid, ready ignores valid", 64'(bad5), 64'(0));
    chk(cnt[0] == 16, "R8", "core 0 grants in 32 clocks", 64'(cnt[0]), 64'(16));
    for (int i = 1; i < NREQ; i++)
      chk(cnt[i] == 1, "R8", "core grant in 32 clocks", 64'(cnt[i]), 64'(1));
  endtask

  task automatic t_rw_all();
    logic [31:0] rd;
    for (int c = 0; c < NREQ; c++)
      do_access(c, 1'b1, 5 + c * 7, 32'hC0DE_0000 ^ (32'(c) << 8) ^ 32'(c * 3), rd);
    for (int c = 0; c < NREQ; c++) begin
      do_access(c, 1'b0, 5 + c * 7, 32'h0, rd);
      chk(rd == (32'hC0DE_0000 ^ (32'(c) << 8) ^ 32'(c * 3)), "R6", "read after write",
          64'(rd), 64'(32'hC0DE_0000 ^ (32'(c) << 8) ^ 32'(c * 3)));
    end
  endtask

  task automatic t_strict();
    int bad, w;
    logic [31:0] rd;
    bad = 0; w = 0;
    @(negedge clk);
    req_valid[9] = 1'b1;
    req_wr[9] = 1'b1;
    req_addr[9*AW +: AW] = AW'(300);
    req_wdata[9*DW +: DW] = 32'h5EED_0009;
    #1;
    while (exp_owner(bc) != 9 && w < 40) begin
      if (grant != '0) bad++;
      @(negedge clk); #1; w++;
    end
    chk(bad == 0, "R4", "no grant outside own slot", 64'(bad), 64'(0));
    chk(grant == (17'(1) << 9), "R4", "grant in slot of core 9", 64'(grant), 64'(1) << 9);
    @(negedge clk);
    req_valid[9] = 1'b0;
    do_access(2, 1'b0, 300, 32'h0, rd);
    chk(rd == 32'h5EED_0009, "R6", "strict write visible to other core", 64'(rd), 64'h5EED_0009);
  endtask

  task automatic t_capacity();
    logic [31:0] rd;
    do_access(4, 1'b1, 0, 32'hA5A5_0001, rd);
    do_access(12, 1'b1, (1 << AW) - 1, 32'h5A5A_FFFF, rd);
    do_access(1, 1'b0, 0, 32'h0, rd);
    chk(rd == 32'hA5A5_0001, "R9", "lowest address", 64'(rd), 64'hA5A5_0001);
    do_access(1, 1'b0, (1 << AW) - 1, 32'h0, rd);
    chk(rd == 32'h5A5A_FFFF, "R9", "highest address", 64'(rd), 64'h5A5A_FFFF);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    req_valid = '0; req_wr = '0; req_addr = '0; req_wdata = '0;
    repeat (2) @(posedge clk);
    t_reset();
    t_schedule();
    t_fairness();
    t_rw_all();
    t_strict();
    t_capacity();
    t_reset();
    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule